// File: doc/BRIEF.md
# Streamed Block Holding Buffer

This block is a small, fully associative store for cache blocks that a stream engine has fetched ahead of demand. Every block held here is clean. A lookup port is probed whenever the L1 misses, alongside the L2. When a probe finds the block, three things happen:

- the data and the identity of the supplying stream queue go back for the L1 fill;
- the slot is freed, because the block now lives in L1;
- the stream engine receives a consumption notice carrying that queue identity, so it can fetch the next block of the stream.

A write to a buffered block by any processor, local or remote, arrives on the invalidate port and drops the slot. Fills allocate in the following order of preference:

- a slot that already holds the same block address, which is refreshed in place;
- otherwise the lowest-numbered empty slot;
- only when every slot is occupied, the least recently filled slot.

An invalidate that lands in the same cycle as a fill of the same block cancels that fill.

Top module: `stream_value_buf`

## Requirements
- R1: After reset the buffer is empty: resp_valid and note_valid are 0, and a first lookup of any address returns resp_hit = 0.
- R2: A lookup of a buffered address returns, on the cycle after lkp_valid is sampled, resp_valid = 1, resp_hit = 1, the full block data and the queue ID of the last fill of that address.
- R3: On every hit, note_valid is 1 in the same cycle as resp_hit, and note_qid equals resp_qid. On a miss or an idle cycle, note_valid is 0.
- R4: A hit removes the entry, so a second lookup of the same address, with no fill in between, misses.
- R5: A lookup of an address that is not held returns resp_valid = 1 and resp_hit = 0 one cycle later.
- R6: An invalidate of a held address removes it, so a later lookup misses.
- R7: A fill and an invalidate of the same address in the same cycle leave no entry for that address.
- R8: A fill whose address is already held overwrites that entry's data and queue ID and creates no second copy. After one hit, a second lookup misses.
- R9: While any slot is empty, a fill takes an empty slot and evicts nothing.
- R10: When all slots are occupied, a fill of a new address evicts the entry whose most recent fill is oldest. A refill of a held address counts as its most recent fill.
- R11: A cycle with lkp_valid = 0 produces resp_valid = 0 and note_valid = 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Fill request from the stream engine |
| fill_addr | input | ADDR_W | Block address of the fill |
| fill_data | input | BLOCK_BYTES*8 | Block contents |
| fill_qid | input | QID_W | Stream queue that supplied the block |
| lkp_valid | input | 1 | Lookup request on an L1 miss |
| lkp_addr | input | ADDR_W | Block address to look up |
| inv_valid | input | 1 | Write seen to a block (any processor) |
| inv_addr | input | ADDR_W | Block address written |
| resp_valid | output | 1 | Lookup response present |
| resp_hit | output | 1 | Lookup found the block |
| resp_data | output | BLOCK_BYTES*8 | Block data for the L1 fill |
| resp_qid | output | QID_W | Queue ID of the hit entry |
| note_valid | output | 1 | Consumption notice to the stream engine |
| note_qid | output | QID_W | Queue to advance |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Repeat lookup after a hit.** A design that forgets to free the slot on a hit would report the same block twice.
- **Invalidate and fill of one address in the same cycle.** A design that lets the fill win would keep a block that has gone stale.
- **Refill of an address already held.** A design that allocates a fresh slot would return a hit on the second lookup, from the stale copy.
- **A single empty slot among full ones.** A design that evicts when a slot is still free would lose a live block.
- **Eviction in a full buffer after one entry is refreshed.** A recency tracker that ignores refreshes would evict the refreshed block instead of the next-oldest one.

// File: rtl/svb_pkg.sv
package svb_pkg;

  localparam int MAX_SLOTS = 64;

  // Index of the lowest set bit, 0 when none is set.
  function automatic logic [5:0] lowest_set(logic [MAX_SLOTS-1:0] v);
    logic [5:0] idx;
    idx = '0;
    for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
      if (v[i]) idx = 6'(i);
    end
    return idx;
  endfunction

  // Recency rank after a touch: the touched slot becomes newest (0),
  // slots that were newer than it age by one, older slots keep their rank.
  function automatic logic [5:0] rank_next(logic [5:0] cur, logic [5:0] touched_rank,
                                           logic is_me);
    if (is_me) return 6'd0;
    if (cur < touched_rank) return cur + 6'd1;
    return cur;
  endfunction

endpackage

// File: rtl/svb_match.sv
module svb_match #(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 26
) (
  input  logic [ENTRIES-1:0]        valid_vec,
  input  logic [ENTRIES*ADDR_W-1:0] tag_flat,
  input  logic [ADDR_W-1:0]         key,
  output logic [ENTRIES-1:0]        hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_vec[g] && (tag_flat[g*ADDR_W +: ADDR_W] == key);
  end
endmodule

// File: rtl/svb_lru.sv
module svb_lru #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  import svb_pkg::*;

  logic [IDX_W-1:0]   rank_q [ENTRIES];
  logic [ENTRIES-1:0] oldest_vec;
  logic [IDX_W-1:0]   touched_rank;

  assign touched_rank = rank_q[touch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < ENTRIES; j++) rank_q[j] <= IDX_W'(j);
    end else if (touch) begin
      for (int j = 0; j < ENTRIES; j++) begin
        rank_q[j] <= IDX_W'(rank_next(6'(rank_q[j]), 6'(touched_rank),
                                      touch_idx == IDX_W'(j)));
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldest_vec[g] = (rank_q[g] == IDX_W'(ENTRIES - 1));
  end

  assign victim_idx = IDX_W'(lowest_set(MAX_SLOTS'(oldest_vec)));
endmodule

// File: rtl/stream_value_buf.sv
module stream_value_buf #(
  parameter int ENTRIES     = 32,
  parameter int ADDR_W      = 26,
  parameter int BLOCK_BYTES = 64,
  parameter int QID_W       = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fill_valid,
  input  logic [ADDR_W-1:0]        fill_addr,
  input  logic [BLOCK_BYTES*8-1:0] fill_data,
  input  logic [QID_W-1:0]         fill_qid,
  input  logic                     lkp_valid,
  input  logic [ADDR_W-1:0]        lkp_addr,
  input  logic                     inv_valid,
  input  logic [ADDR_W-1:0]        inv_addr,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic [BLOCK_BYTES*8-1:0] resp_data,
  output logic [QID_W-1:0]         resp_qid,
  output logic                     note_valid,
  output logic [QID_W-1:0]         note_qid
);
  import svb_pkg::*;

  localparam int DATA_W = BLOCK_BYTES * 8;
  localparam int IDX_W  = $clog2(ENTRIES);

  // storage
  logic [ENTRIES-1:0]        valid_q;
  logic [ADDR_W-1:0]         tag_q  [ENTRIES];
  logic [DATA_W-1:0]         data_q [ENTRIES];
  logic [QID_W-1:0]          qid_q  [ENTRIES];
  logic [ENTRIES*ADDR_W-1:0] tag_flat;

  // named internal events
  logic [ENTRIES-1:0] lkp_match, fill_hit_vec, inv_match;
  logic [ENTRIES-1:0] lkp_take, inv_kill, free_vec;
  logic               clash, fill_go, any_hit;
  logic [IDX_W-1:0]   alloc_idx, victim_idx;
  logic [DATA_W-1:0]  sel_data;
  logic [QID_W-1:0]   sel_qid;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign tag_flat[g*ADDR_W +: ADDR_W] = tag_q[g];
  end

  svb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) lkp_m (
    .valid_vec(valid_q), .tag_flat(tag_flat), .key(lkp_addr), .hit_vec(lkp_match));
  svb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) fill_m (
    .valid_vec(valid_q), .tag_flat(tag_flat), .key(fill_addr), .hit_vec(fill_hit_vec));
  svb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) inv_m (
    .valid_vec(valid_q), .tag_flat(tag_flat), .key(inv_addr), .hit_vec(inv_match));

  svb_lru #(.ENTRIES(ENTRIES)) lru_i (
    .clk(clk), .rst_n(rst_n), .touch(fill_go), .touch_idx(alloc_idx),
    .victim_idx(victim_idx));

  always_comb begin
    lkp_take = lkp_valid ? lkp_match : '0;
    inv_kill = inv_valid ? inv_match : '0;
    any_hit  = |lkp_take;
    clash    = fill_valid && inv_valid && (fill_addr == inv_addr);
    fill_go  = fill_valid && !clash;
    free_vec = ~valid_q;
    if (|fill_hit_vec)
      alloc_idx = IDX_W'(lowest_set(MAX_SLOTS'(fill_hit_vec)));
    else if (|free_vec)
      alloc_idx = IDX_W'(lowest_set(MAX_SLOTS'(free_vec)));
    else
      alloc_idx = victim_idx;
  end

  // one-hot read mux
  always_comb begin
    sel_data = '0;
    sel_qid  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkp_take[i]) begin
        sel_data = sel_data | data_q[i];
        sel_qid  = sel_qid  | qid_q[i];
      end
    end
  end

  // occupancy: a fill write outranks a clear in the same slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_go && alloc_idx == IDX_W'(i))
          valid_q[i] <= 1'b1;
        else if (lkp_take[i] || inv_kill[i])
          valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[alloc_idx]  <= fill_addr;
      data_q[alloc_idx] <= fill_data;
      qid_q[alloc_idx]  <= fill_qid;
    end
  end

  // registered response and consumption notice
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
      resp_qid   <= '0;
      note_valid <= 1'b0;
      note_qid   <= '0;
    end else begin
      resp_valid <= lkp_valid;
      resp_hit   <= any_hit;
      resp_data  <= sel_data;
      resp_qid   <= sel_qid;
      note_valid <= any_hit;
      note_qid   <= sel_qid;
    end
  end
endmodule

// File: rtl/svb_chk.sv
module svb_chk #(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 26
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lkp_valid,
  input logic                      resp_valid,
  input logic                      resp_hit,
  input logic                      note_valid,
  input logic                      fill_valid,
  input logic [ADDR_W-1:0]         fill_addr,
  input logic                      inv_valid,
  input logic [ADDR_W-1:0]         inv_addr,
  input logic [ENTRIES-1:0]        valid_vec,
  input logic [ENTRIES*ADDR_W-1:0] tag_flat,
  input logic [ENTRIES-1:0]        fill_hit_vec
);
  logic [ADDR_W-1:0] prev_inv_q;
  int                copies_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_inv_q <= '0;
    else        prev_inv_q <= inv_addr;
  end

  always_comb begin
    copies_prev = 0;
    for (int i = 0; i < ENTRIES; i++)
      if (valid_vec[i] && tag_flat[i*ADDR_W +: ADDR_W] == prev_inv_q) copies_prev++;
  end

  // R5
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> resp_valid);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> (!resp_valid && !note_valid));
  // R3
  note_tracks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid == (resp_valid && resp_hit));
  // R8
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_hit_vec));
  // R6
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> (copies_prev == 0));
  // R7
  clash_drops_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && inv_valid && fill_addr == inv_addr) |=> (copies_prev == 0));
endmodule

bind stream_value_buf svb_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .resp_valid(resp_valid),
  .resp_hit(resp_hit), .note_valid(note_valid), .fill_valid(fill_valid),
  .fill_addr(fill_addr), .inv_valid(inv_valid), .inv_addr(inv_addr),
  .valid_vec(valid_q), .tag_flat(tag_flat), .fill_hit_vec(fill_hit_vec));

// File: tb/stream_value_buf_tb_top.sv
`timescale 1ns/1ps
module stream_value_buf_tb_top;
  localparam int N  = 32;
  localparam int AW = 26;
  localparam int DW = 512;
  localparam int QW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_valid = 0, lkp_valid = 0, inv_valid = 0;
  logic [AW-1:0] fill_addr = '0, lkp_addr = '0, inv_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic [QW-1:0] fill_qid = '0;
  logic resp_valid, resp_hit, note_valid;
  logic [DW-1:0] resp_data;
  logic [QW-1:0] resp_qid, note_qid;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stream_value_buf dut_i (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_data(fill_data), .fill_qid(fill_qid), .lkp_valid(lkp_valid),
    .lkp_addr(lkp_addr), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .resp_qid(resp_qid), .note_valid(note_valid), .note_qid(note_qid));

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a, logic [QW-1:0] q);
    return {16{q, 3'b101, a}};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(logic [AW-1:0] a, logic [QW-1:0] q);
    @(negedge clk);
    fill_valid = 1; fill_addr = a; fill_qid = q; fill_data = pat(a, q);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic inval(logic [AW-1:0] a);
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    @(negedge clk);
    inv_valid = 0;
  endtask

  // response is registered at the edge between the two negedges
  task automatic look(logic [AW-1:0] a, output logic v, output logic h,
                      output logic [DW-1:0] d, output logic [QW-1:0] q,
                      output logic nv, output logic [QW-1:0] nq);
    @(negedge clk);
    lkp_valid = 1; lkp_addr = a;
    @(negedge clk);
    lkp_valid = 0;
    v = resp_valid; h = resp_hit; d = resp_data; q = resp_qid;
    nv = note_valid; nq = note_qid;
  endtask

  logic v, h, nv;
  logic [DW-1:0] d;
  logic [QW-1:0] q, nq;

  task automatic t_reset();
    chk(resp_valid == 0 && note_valid == 0, "R1 idle outputs", {resp_valid, note_valid}, 0);
    look(26'h0AA, v, h, d, q, nv, nq);
    chk(v == 1 && h == 0, "R1 empty after reset", {v, h}, 2'b10);
  endtask

  task automatic t_basic();
    fill(26'h1234, 3'd2);
    look(26'h1234, v, h, d, q, nv, nq);
    chk(v && h, "R2 hit", {v, h}, 2'b11);
    chk(d == pat(26'h1234, 3'd2) && q == 3'd2, "R2 data/qid", {d[59:0], q}, {pat(26'h1234, 3'd2)[59:0], 3'd2});
    chk(nv == 1 && nq == 3'd2, "R3 notice on hit", {nv, nq}, {1'b1, 3'd2});
    look(26'h1234, v, h, d, q, nv, nq);
    chk(v == 1 && h == 0, "R4 entry removed by hit", {v, h}, 2'b10);
    chk(nv == 0, "R3 no notice on miss", nv, 0);
    look(26'h5555, v, h, d, q, nv, nq);
    chk(v == 1 && h == 0, "R5 miss response", {v, h}, 2'b10);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk(resp_valid == 0 && note_valid == 0, "R11 idle cycle quiet", {resp_valid, note_valid}, 0);
  endtask

  task automatic t_inval();
    fill(26'h0B0B, 3'd1);
    inval(26'h0B0B);
    look(26'h0B0B, v, h, d, q, nv, nq);
    chk(h == 0, "R6 invalidate removes block", h, 0);
  endtask

  task automatic t_clash();
    @(negedge clk);
    fill_valid = 1; fill_addr = 26'h0C0C; fill_qid = 3'd4; fill_data = pat(26'h0C0C, 3'd4);
    inv_valid = 1; inv_addr = 26'h0C0C;
    @(negedge clk);
    fill_valid = 0; inv_valid = 0;
    look(26'h0C0C, v, h, d, q, nv, nq);
    chk(h == 0, "R7 same-cycle invalidate drops fill", h, 0);
  endtask

  task automatic t_dup();
    fill(26'h0D0D, 3'd1);
    fill(26'h0D0D, 3'd5);
    look(26'h0D0D, v, h, d, q, nv, nq);
    chk(h && q == 3'd5 && d == pat(26'h0D0D, 3'd5), "R8 refill updates entry", {h, q}, {1'b1, 3'd5});
    look(26'h0D0D, v, h, d, q, nv, nq);
    chk(h == 0, "R8 no duplicate copy", h, 0);
  endtask

  task automatic t_free();
    int hits = 0;
    for (int i = 0; i < N; i++) fill(AW'(32'h100 + i), QW'(i));
    inval(26'h107);
    fill(26'h3F00, 3'd6);
    for (int i = 0; i < N; i++) begin
      look(AW'(32'h100 + i), v, h, d, q, nv, nq);
      if (i == 7) chk(h == 0, "R9 invalidated slot stays gone", h, 0);
      else if (h && d == pat(AW'(32'h100 + i), QW'(i))) hits++;
    end
    chk(hits == N - 1, "R9 free slot used, nothing evicted", 64'(hits), 64'(N - 1));
    look(26'h3F00, v, h, d, q, nv, nq);
    chk(h && q == 3'd6, "R9 new block present", {h, q}, {1'b1, 3'd6});
  endtask

  task automatic t_lru();
    for (int i = 0; i < N; i++) fill(AW'(32'h200 + i), 3'd1);
    fill(26'h200, 3'd3);
    fill(26'h2FFF, 3'd7);
    look(26'h201, v, h, d, q, nv, nq);
    chk(h == 0, "R10 oldest fill evicted", h, 0);
    look(26'h200, v, h, d, q, nv, nq);
    chk(h && q == 3'd3, "R10 refreshed block kept", {h, q}, {1'b1, 3'd3});
    look(26'h2FFF, v, h, d, q, nv, nq);
    chk(h && q == 3'd7, "R10 new block present", {h, q}, {1'b1, 3'd7});
    look(26'h202, v, h, d, q, nv, nq);
    chk(h == 1, "R10 next-oldest kept", h, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_idle();
    t_inval();
    t_clash();
    t_dup();
    t_free();
    t_lru();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule